// File: doc/BRIEF.md
# Ping-pong bulk endpoint buffer controller

This block manages the two 512-byte halves of a shared buffer memory that carry one bulk endpoint between a USB packet engine and a disk DMA port. One side produces data into a half and the other side consumes it. A direction input picks which side is which. While the producer fills one half, the consumer drains the other, so the stream can keep moving without a pause.

The block does not hold the data. It drives a byte address for each side, a ready flag that tells each side whether its next word access may go ahead, and full and empty flags for each half. It also exposes the byte count committed into each half. The producer passes a half to the consumer by committing a byte count. The consumer hands the half back after reading enough 32-bit words to cover that count. Only one direction is buffered at a time. Changing the direction clears both halves.

Top module: `ppbuf_ctrl`

## Requirements
- R1: After reset the state is as follows: both halves empty and neither full (`full_o`=00, `empty_o`=11), both addresses at 0x100, the packet side ready and the disk side not ready (direction 0).
- R2: With `dir_i`=0 the packet side is the producer. Its address starts at the base of its current half (half A at 0x100, half B at 0x300). It advances by 4 for each write accepted while `pkt_ready_o` is high.
- R3: A producer commit with a nonzero count, while the producer's half is not full, does the following: it marks that half full (`full_o` bit 0 = half A, bit 1 = half B), it stores the count, and it moves the producer to the other half at offset 0. A write in the same cycle uses the old address.
- R4: The consumer is ready only when its current half is full. Its address is the half base plus 4 per accepted read. The read whose start offset plus 4 reaches the stored count empties the half and moves the consumer to the other half at offset 0.
- R5: The producer is not ready while its current half is full. A write request while it is not ready leaves the address and all state unchanged.
- R6: After 512 bytes have been written into a half without a commit, the producer is not ready. Its address stays at base plus 512 until a commit.
- R7: A commit with a count of zero, or a commit while the producer's half is full, has no effect.
- R8: With `dir_i`=1 the roles swap. The disk side produces and commits, and the packet side consumes.
- R9: In the cycle where `dir_i` differs from the registered direction, both ready flags are low and all requests are ignored. At the next edge both halves become empty with count 0, and both sides point at half A offset 0.
- R10: A committed count above 512 is stored as 512.
- R11: A half is reported empty only when it is not full and the producer has not written into it since it last became the producer's half.
- R12: Commit inputs on the consumer side have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_i | input | 1 | 0: packet side fills, disk side drains; 1: reverse |
| pkt_xfer_i | input | 1 | Packet side requests one 32-bit word access |
| pkt_commit_i | input | 1 | Packet side hands its half over (used when producer) |
| pkt_bytes_i | input | 11 | Byte count given with a packet-side commit |
| pkt_addr_o | output | 11 | Byte address for the packet side's access |
| pkt_ready_o | output | 1 | Packet side access may go ahead this cycle |
| dsk_xfer_i | input | 1 | Disk side requests one 32-bit word access |
| dsk_commit_i | input | 1 | Disk side hands its half over (used when producer) |
| dsk_bytes_i | input | 11 | Byte count given with a disk-side commit |
| dsk_addr_o | output | 11 | Byte address for the disk side's access |
| dsk_ready_o | output | 1 | Disk side access may go ahead this cycle |
| full_o | output | 2 | Half owned by consumer (bit 0 A, bit 1 B) |
| empty_o | output | 2 | Half holds no data (bit 0 A, bit 1 B) |
| cnt_a_o | output | 10 | Byte count last committed into half A |
| cnt_b_o | output | 10 | Byte count last committed into half B |

## Verification
Directed sequences come first. They cover three things: a short fill-commit-drain round trip, a producer that laps the consumer and stalls, and a producer that writes a whole half without committing. The round trip tells the two address bases apart. The stall tells ownership gating apart from the per-half room limit. A run of random word requests, commits with counts from 0 to 599, and rare direction flips is then checked every cycle against a bench model. That run separates the exact drain-release point for counts that are not word multiples. It also shows that clamping and zero-count commits are handled, and that flips arriving mid-stream clear all state.

// File: rtl/ppbuf_pkg.sv
// Shared types for the ping-pong buffer controller.
package ppbuf_pkg;
    typedef enum logic {HALF_A = 1'b0, HALF_B = 1'b1} half_e;

    // Return the opposite half.
    function automatic half_e other_half(half_e h);
        return (h == HALF_A) ? HALF_B : HALF_A;
    endfunction
endpackage

// File: rtl/ppbuf_cursor.sv
// Half selector plus byte offset for one side (producer or consumer).
// Assumes: flip wins over step; clr returns to half A offset 0.
module ppbuf_cursor
    import ppbuf_pkg::*;
#(
    parameter int OFF_W = 10,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             flip,
    output half_e            half_o,
    output logic [OFF_W-1:0] off_o
);
    localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);

    // Track current half and byte offset inside it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            half_o <= HALF_A;
            off_o  <= '0;
        end else if (flip) begin
            half_o <= other_half(half_o);
            off_o  <= '0;
        end else if (step) begin
            off_o  <= off_o + STEP_V;
        end
    end
endmodule

// File: rtl/ppbuf_slot.sv
// Ownership flag and committed byte count for one buffer half.
// Assumes: load and drop are never high together (guaranteed by the top).
module ppbuf_slot #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             drop_i,
    output logic             full_o,
    output logic [CNT_W-1:0] cnt_o
);
    // Hand the half to the consumer on load, back on drop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            full_o <= 1'b0;
            cnt_o  <= '0;
        end else if (load) begin
            full_o <= 1'b1;
            cnt_o  <= load_cnt;
        end else if (drop_i) begin
            full_o <= 1'b0;
        end
    end
endmodule

// File: rtl/ppbuf_role_mux.sv
// Maps the packet and disk ports onto producer and consumer roles.
// Assumes: dir 0 makes the packet side the producer.
module ppbuf_role_mux #(
    parameter int ADDR_W = 11,
    parameter int BYTES_W = 11
) (
    input  logic               dir,
    input  logic               pkt_xfer,
    input  logic               pkt_commit,
    input  logic [BYTES_W-1:0] pkt_bytes,
    input  logic               dsk_xfer,
    input  logic               dsk_commit,
    input  logic [BYTES_W-1:0] dsk_bytes,
    input  logic [ADDR_W-1:0]  prod_addr,
    input  logic [ADDR_W-1:0]  cons_addr,
    input  logic               prod_ready,
    input  logic               cons_ready,
    output logic               prod_xfer,
    output logic               prod_commit,
    output logic [BYTES_W-1:0] prod_bytes,
    output logic               cons_xfer,
    output logic [ADDR_W-1:0]  pkt_addr,
    output logic               pkt_ready,
    output logic [ADDR_W-1:0]  dsk_addr,
    output logic               dsk_ready
);
    // Route requests in and addresses/ready out by direction.
    always_comb begin
        if (!dir) begin
            prod_xfer   = pkt_xfer;
            prod_commit = pkt_commit;
            prod_bytes  = pkt_bytes;
            cons_xfer   = dsk_xfer;
            pkt_addr    = prod_addr;
            pkt_ready   = prod_ready;
            dsk_addr    = cons_addr;
            dsk_ready   = cons_ready;
        end else begin
            prod_xfer   = dsk_xfer;
            prod_commit = dsk_commit;
            prod_bytes  = dsk_bytes;
            cons_xfer   = pkt_xfer;
            pkt_addr    = cons_addr;
            pkt_ready   = cons_ready;
            dsk_addr    = prod_addr;
            dsk_ready   = prod_ready;
        end
    end
endmodule

// File: rtl/ppbuf_ctrl.sv
// Ping-pong buffer controller for one bulk endpoint. Two fixed halves are
// handed between producer and consumer by committed byte counts; a
// direction bit swaps the roles of the packet and disk sides.
// Assumes: one 32-bit word per accepted access; addresses are byte addresses.
module ppbuf_ctrl
    import ppbuf_pkg::*;
#(
    parameter int                 HALF_BYTES = 512,
    parameter int                 WORD_BYTES = 4,
    parameter int                 ADDR_W     = 11,
    parameter logic [ADDR_W-1:0]  BASE_A     = 11'h100,
    parameter logic [ADDR_W-1:0]  BASE_B     = 11'h300
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                dir_i,
    input  logic                                pkt_xfer_i,
    input  logic                                pkt_commit_i,
    input  logic [$clog2(HALF_BYTES)+1:0]       pkt_bytes_i,
    output logic [ADDR_W-1:0]                   pkt_addr_o,
    output logic                                pkt_ready_o,
    input  logic                                dsk_xfer_i,
    input  logic                                dsk_commit_i,
    input  logic [$clog2(HALF_BYTES)+1:0]       dsk_bytes_i,
    output logic [ADDR_W-1:0]                   dsk_addr_o,
    output logic                                dsk_ready_o,
    output logic [1:0]                          full_o,
    output logic [1:0]                          empty_o,
    output logic [$clog2(HALF_BYTES):0]         cnt_a_o,
    output logic [$clog2(HALF_BYTES):0]         cnt_b_o
);
    localparam int CNT_W   = $clog2(HALF_BYTES) + 1;
    localparam int BYTES_W = CNT_W + 1;
    localparam logic [CNT_W-1:0]   HALF_V  = CNT_W'(HALF_BYTES);
    localparam logic [BYTES_W-1:0] HALF_BV = BYTES_W'(HALF_BYTES);
    localparam logic [BYTES_W-1:0] WORD_BV = BYTES_W'(WORD_BYTES);

    logic               dir_q;
    logic               chg;
    half_e              prod_half, cons_half;
    logic [CNT_W-1:0]   fill, drain;
    logic [1:0]         slot_full;
    logic [CNT_W-1:0]   slot_cnt [2];
    logic               prod_xfer, prod_commit, cons_xfer;
    logic [BYTES_W-1:0] prod_bytes;
    logic [CNT_W-1:0]   bytes_cl;
    logic               prod_ready, cons_ready;
    logic               prod_wr, prod_commit_ok, cons_rd, cons_last, cons_drop;
    logic [BYTES_W-1:0] drain_next;
    logic [ADDR_W-1:0]  prod_addr, cons_addr;

    // Register the direction so a change is seen for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= 1'b0;
        else        dir_q <= dir_i;
    end

    // Ownership gates, clamping and release detection.
    always_comb begin
        chg            = dir_i != dir_q;
        prod_ready     = !chg && !slot_full[prod_half] && (fill != HALF_V);
        cons_ready     = !chg && slot_full[cons_half];
        prod_wr        = prod_xfer && prod_ready;
        prod_commit_ok = prod_commit && !chg && !slot_full[prod_half]
                         && (prod_bytes != '0);
        bytes_cl       = (prod_bytes > HALF_BV) ? HALF_V : prod_bytes[CNT_W-1:0];
        cons_rd        = cons_xfer && cons_ready;
        drain_next     = {1'b0, drain} + WORD_BV;
        cons_last      = drain_next >= {1'b0, slot_cnt[cons_half]};
        cons_drop      = cons_rd && cons_last;
    end

    // Byte addresses from half base plus offset.
    always_comb begin
        prod_addr = ((prod_half == HALF_A) ? BASE_A : BASE_B) + ADDR_W'(fill);
        cons_addr = ((cons_half == HALF_A) ? BASE_A : BASE_B) + ADDR_W'(drain);
    end

    ppbuf_role_mux #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W)) u_mux (
        .dir        (dir_q),
        .pkt_xfer   (pkt_xfer_i),
        .pkt_commit (pkt_commit_i),
        .pkt_bytes  (pkt_bytes_i),
        .dsk_xfer   (dsk_xfer_i),
        .dsk_commit (dsk_commit_i),
        .dsk_bytes  (dsk_bytes_i),
        .prod_addr  (prod_addr),
        .cons_addr  (cons_addr),
        .prod_ready (prod_ready),
        .cons_ready (cons_ready),
        .prod_xfer  (prod_xfer),
        .prod_commit(prod_commit),
        .prod_bytes (prod_bytes),
        .cons_xfer  (cons_xfer),
        .pkt_addr   (pkt_addr_o),
        .pkt_ready  (pkt_ready_o),
        .dsk_addr   (dsk_addr_o),
        .dsk_ready  (dsk_ready_o)
    );

    ppbuf_cursor #(.OFF_W(CNT_W), .STEP(WORD_BYTES)) u_prod_cur (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chg),
        .step  (prod_wr),
        .flip  (prod_commit_ok),
        .half_o(prod_half),
        .off_o (fill)
    );

    ppbuf_cursor #(.OFF_W(CNT_W), .STEP(WORD_BYTES)) u_cons_cur (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chg),
        .step  (cons_rd),
        .flip  (cons_drop),
        .half_o(cons_half),
        .off_o (drain)
    );

    // One ownership slot per half, plus its empty flag.
    for (genvar g = 0; g < 2; g++) begin : g_slot
        localparam half_e ME = (g == 0) ? HALF_A : HALF_B;

        ppbuf_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (chg),
            .load    (prod_commit_ok && (prod_half == ME)),
            .load_cnt(bytes_cl),
            .drop_i  (cons_drop && (cons_half == ME)),
            .full_o  (slot_full[g]),
            .cnt_o   (slot_cnt[g])
        );

        assign empty_o[g] = !slot_full[g] && !((prod_half == ME) && (fill != '0));
    end

    assign full_o  = slot_full;
    assign cnt_a_o = slot_cnt[0];
    assign cnt_b_o = slot_cnt[1];
endmodule

// File: rtl/ppbuf_ctrl_chk.sv
// Property checker for ppbuf_ctrl, bound to every instance.
module ppbuf_ctrl_chk #(
    parameter int                ADDR_W     = 11,
    parameter int                WORD_BYTES = 4,
    parameter logic [ADDR_W-1:0] BASE_A     = 11'h100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_i,
    input logic              dir_q,
    input logic [1:0]        full_o,
    input logic [1:0]        empty_o,
    input logic              pkt_ready_o,
    input logic              dsk_ready_o,
    input logic [ADDR_W-1:0] pkt_addr_o,
    input logic [ADDR_W-1:0] dsk_addr_o,
    input logic              prod_half,
    input logic              cons_half,
    input logic              prod_ready,
    input logic              cons_ready,
    input logic              prod_wr,
    input logic              prod_commit_ok,
    input logic [ADDR_W-1:0] prod_addr
);
    p_full_not_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o & empty_o) == 2'b00);

    p_prod_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prod_ready |-> !full_o[prod_half]);

    p_cons_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cons_ready |-> full_o[cons_half]);

    p_change_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_i != dir_q) |-> (!pkt_ready_o && !dsk_ready_o));

    p_change_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_i != dir_q) |=> (full_o == 2'b00 && pkt_addr_o == BASE_A
                              && dsk_addr_o == BASE_A));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_wr && !prod_commit_ok) |=>
            (prod_addr == $past(prod_addr) + ADDR_W'(WORD_BYTES)));

    p_commit_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prod_commit_ok |=> (prod_half != $past(prod_half)));
endmodule

bind ppbuf_ctrl ppbuf_ctrl_chk #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BASE_A(BASE_A)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dir_i         (dir_i),
    .dir_q         (dir_q),
    .full_o        (full_o),
    .empty_o       (empty_o),
    .pkt_ready_o   (pkt_ready_o),
    .dsk_ready_o   (dsk_ready_o),
    .pkt_addr_o    (pkt_addr_o),
    .dsk_addr_o    (dsk_addr_o),
    .prod_half     (prod_half),
    .cons_half     (cons_half),
    .prod_ready    (prod_ready),
    .cons_ready    (cons_ready),
    .prod_wr       (prod_wr),
    .prod_commit_ok(prod_commit_ok),
    .prod_addr     (prod_addr)
);

// File: tb/test_ppbuf_ctrl.sv
module test_ppbuf_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_i = 1'b0;
    logic        pkt_xfer_i = 1'b0, pkt_commit_i = 1'b0;
    logic [10:0] pkt_bytes_i = '0;
    logic        dsk_xfer_i = 1'b0, dsk_commit_i = 1'b0;
    logic [10:0] dsk_bytes_i = '0;
    logic [10:0] pkt_addr_o, dsk_addr_o;
    logic        pkt_ready_o, dsk_ready_o;
    logic [1:0]  full_o, empty_o;
    logic [9:0]  cnt_a_o, cnt_b_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    bit m_dir;
    bit m_full [2];
    int m_cnt [2];
    int m_ph, m_ch, m_fill, m_drain;

    always #4 clk = ~clk;

    ppbuf_ctrl i_ppbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_i),
        .pkt_xfer_i(pkt_xfer_i), .pkt_commit_i(pkt_commit_i), .pkt_bytes_i(pkt_bytes_i),
        .pkt_addr_o(pkt_addr_o), .pkt_ready_o(pkt_ready_o),
        .dsk_xfer_i(dsk_xfer_i), .dsk_commit_i(dsk_commit_i), .dsk_bytes_i(dsk_bytes_i),
        .dsk_addr_o(dsk_addr_o), .dsk_ready_o(dsk_ready_o),
        .full_o(full_o), .empty_o(empty_o), .cnt_a_o(cnt_a_o), .cnt_b_o(cnt_b_o)
    );

    task automatic chk(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int base_of(int h);
        return (h == 0) ? 'h100 : 'h300;
    endfunction

    function automatic void model_clear();
        m_full[0] = 0; m_full[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
        m_ph = 0; m_ch = 0; m_fill = 0; m_drain = 0;
    endfunction

    function automatic bit e_prod_rdy();
        return (dir_i == m_dir) && !m_full[m_ph] && (m_fill != 512);
    endfunction

    function automatic bit e_cons_rdy();
        return (dir_i == m_dir) && m_full[m_ch];
    endfunction

    function automatic int e_empty();
        int r = 0;
        for (int h = 0; h < 2; h++)
            if (!m_full[h] && !(m_ph == h && m_fill != 0)) r |= (1 << h);
        return r;
    endfunction

    // Compare every output with the model before the edge.
    task automatic compare_all();
        int pa = m_dir ? base_of(m_ch) + m_drain : base_of(m_ph) + m_fill;
        int da = m_dir ? base_of(m_ph) + m_fill  : base_of(m_ch) + m_drain;
        chk(int'(pkt_addr_o), pa, "R2/R4 pkt addr");
        chk(int'(dsk_addr_o), da, "R2/R4 dsk addr");
        chk(int'(pkt_ready_o), m_dir ? e_cons_rdy() : e_prod_rdy(), "R5 pkt ready");
        chk(int'(dsk_ready_o), m_dir ? e_prod_rdy() : e_cons_rdy(), "R5 dsk ready");
        chk(int'(full_o), (m_full[1] << 1) | m_full[0], "R3 full");
        chk(int'(empty_o), e_empty(), "R11 empty");
        chk(int'(cnt_a_o), m_cnt[0], "R10 count A");
        chk(int'(cnt_b_o), m_cnt[1], "R10 count B");
    endtask

    // Advance the model by one edge using the current inputs.
    function automatic void model_step();
        bit px, pc, cx, pr, pcok, cr;
        int pb;
        if (dir_i != m_dir) begin
            model_clear();
            m_dir = dir_i;
            return;
        end
        px = m_dir ? dsk_xfer_i : pkt_xfer_i;
        pc = m_dir ? dsk_commit_i : pkt_commit_i;
        pb = m_dir ? int'(dsk_bytes_i) : int'(pkt_bytes_i);
        cx = m_dir ? pkt_xfer_i : dsk_xfer_i;
        pr   = !m_full[m_ph] && m_fill != 512;
        pcok = pc && !m_full[m_ph] && pb != 0;
        cr   = cx && m_full[m_ch];
        if (cr) begin
            if (m_drain + 4 >= m_cnt[m_ch]) begin
                m_full[m_ch] = 0; m_ch ^= 1; m_drain = 0;
            end else m_drain += 4;
        end
        if (pcok) begin
            m_full[m_ph] = 1; m_cnt[m_ph] = (pb > 512) ? 512 : pb;
            m_ph ^= 1; m_fill = 0;
        end else if (px && pr) m_fill += 4;
    endfunction

    task automatic step_cycle();
        #1;
        compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic drive(bit px, bit pc, int pb, bit dx, bit dc, int db);
        pkt_xfer_i = px; pkt_commit_i = pc; pkt_bytes_i = 11'(pb);
        dsk_xfer_i = dx; dsk_commit_i = dc; dsk_bytes_i = 11'(db);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd4711);
        m_dir = 0; model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(int'(full_o), 0, "R1 full");
        chk(int'(empty_o), 3, "R1 empty");
        chk(int'(pkt_ready_o), 1, "R1 pkt ready");
        chk(int'(dsk_ready_o), 0, "R1 dsk ready");
        chk(int'(pkt_addr_o), 'h100, "R1 pkt addr");
        chk(int'(dsk_addr_o), 'h100, "R1 dsk addr");

        // R2 three writes into half A
        for (int i = 0; i < 3; i++) begin
            drive(1, 0, 0, 0, 0, 0);
            #1 chk(int'(pkt_addr_o), 'h100 + 4 * i, "R2 write addr");
            step_cycle();
        end
        drive(0, 0, 0, 0, 0, 0);
        #1 chk(int'(empty_o), 2, "R11 partly filled A not empty");
        // R3 commit 10 bytes
        drive(0, 1, 10, 0, 0, 0);
        step_cycle();
        drive(0, 0, 0, 0, 0, 0);
        #1;
        chk(int'(full_o), 1, "R3 A full");
        chk(int'(cnt_a_o), 10, "R3 count A");
        chk(int'(pkt_addr_o), 'h300, "R3 producer to B");
        chk(int'(dsk_ready_o), 1, "R4 consumer ready");
        // R4 drain three words for 10 bytes
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 0, 1, 0, 0);
            #1 chk(int'(dsk_addr_o), 'h100 + 4 * i, "R4 read addr");
            step_cycle();
        end
        drive(0, 0, 0, 0, 0, 0);
        #1;
        chk(int'(full_o), 0, "R4 A released");
        chk(int'(dsk_addr_o), 'h300, "R4 consumer to B");
        chk(int'(dsk_ready_o), 0, "R4 consumer not ready");
        // R7 zero-count commit
        drive(0, 1, 0, 0, 0, 0);
        step_cycle();
        drive(0, 0, 0, 0, 0, 0);
        #1 chk(int'(full_o), 0, "R7 zero commit ignored");
        // R12 consumer-side commit
        drive(0, 0, 0, 0, 1, 8);
        step_cycle();
        drive(0, 0, 0, 0, 0, 0);
        #1 chk(int'(full_o), 0, "R12 consumer commit ignored");
        chk(int'(pkt_addr_o), 'h300, "R12 producer unmoved");
        // R5 producer laps consumer
        drive(1, 1, 4, 0, 0, 0);
        step_cycle();
        drive(1, 1, 4, 0, 0, 0);
        step_cycle();
        drive(1, 0, 0, 0, 0, 0);
        #1 chk(int'(pkt_ready_o), 0, "R5 stalled on full half");
        step_cycle();
        drive(1, 1, 8, 0, 0, 0);
        step_cycle();
        drive(0, 0, 0, 0, 0, 0);
        #1;
        chk(int'(pkt_addr_o), 'h300, "R5 stalled address held");
        chk(int'(full_o), 3, "R7 commit on full half ignored");
        chk(int'(cnt_b_o), 4, "R7 count unchanged");
        // Drain B (4 bytes) to free it
        drive(0, 0, 0, 1, 0, 0);
        step_cycle();
        drive(0, 0, 0, 0, 0, 0);
        #1 chk(int'(pkt_ready_o), 1, "R5 ready after release");
        // R6 fill whole half B without commit
        for (int i = 0; i < 128; i++) begin
            drive(1, 0, 0, 0, 0, 0);
            step_cycle();
        end
        #1;
        chk(int'(pkt_ready_o), 0, "R6 half exhausted");
        chk(int'(pkt_addr_o), 'h500, "R6 address at end");
        step_cycle();
        #1 chk(int'(pkt_addr_o), 'h500, "R6 address held");
        // R10 clamp
        drive(0, 1, 700, 0, 0, 0);
        step_cycle();
        drive(0, 0, 0, 0, 0, 0);
        #1 chk(int'(cnt_b_o), 512, "R10 clamped count");
        // R9 direction change
        dir_i = 1'b1;
        drive(1, 1, 4, 1, 1, 4);
        #1;
        chk(int'(pkt_ready_o), 0, "R9 pkt ready low");
        chk(int'(dsk_ready_o), 0, "R9 dsk ready low");
        step_cycle();
        drive(0, 0, 0, 0, 0, 0);
        #1;
        chk(int'(full_o), 0, "R9 cleared full");
        chk(int'(empty_o), 3, "R9 cleared empty");
        chk(int'(cnt_b_o), 0, "R9 cleared count");
        chk(int'(pkt_addr_o), 'h100, "R9 pkt at A");
        chk(int'(dsk_addr_o), 'h100, "R9 dsk at A");
        chk(int'(dsk_ready_o), 1, "R8 disk side produces");
        chk(int'(pkt_ready_o), 0, "R8 packet side consumes");
        // R8 reversed flow
        drive(0, 0, 0, 1, 0, 0);
        step_cycle();
        drive(0, 0, 0, 1, 1, 8);
        #1 chk(int'(dsk_addr_o), 'h104, "R8 disk write addr");
        step_cycle();
        drive(0, 0, 0, 0, 0, 0);
        #1;
        chk(int'(pkt_ready_o), 1, "R8 packet side drains");
        chk(int'(cnt_a_o), 8, "R8 count A");

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            if ($urandom % 250 == 0) dir_i = ~dir_i;
            drive(($urandom % 3) != 0, ($urandom % 24) == 0, $urandom % 600,
                  ($urandom % 3) != 0, ($urandom % 24) == 0, $urandom % 600);
            step_cycle();
        end
        drive(0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule